// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side command logic of a serial configuration flash. It handles only the status register. It listens on a four-wire serial link made of an active-low chip select, a serial clock, a data input and a data output. It runs on a fast system clock, and every link input passes through a synchroniser before use. Each command opens with an 8-bit opcode, sent most significant bit first. Three commands are supported:

- **Write enable** arms a write-enable latch.
- **Read status** streams the status byte back for as long as chip select stays low.
- **Write status** replaces the block-protect field of the status register.

A write status command is accepted only when three things hold: the latch is armed, no write is in progress, and chip select rises exactly on the byte boundary after one data byte. An accepted command starts a self-timed busy period whose length is a parameter in system clock cycles. During that period the write-in-progress flag reads 1. When the period ends, the flag returns to 0 and the write-enable latch clears. The block-protect bits are also driven out on their own port, for a later protection stage.

Top module: `sflash_status_resp`

## Requirements
- R1: Opcode 8'h06, followed by chip select rising right after its eighth bit, sets the write-enable latch (status bit 1). A frame with extra bits after the opcode leaves the latch unchanged.
- R2: Opcode 8'h05 returns the status byte on the data output, most significant bit first, and repeats it for as long as chip select stays low. The byte is {3'b000, protect[2:0], latch, busy}. The output changes only after a falling serial clock edge, and input bits are sampled on rising edges.
- R3: Opcode 8'h01 followed by a data byte is committed only when chip select rises right after the eighth data bit. Frames of 7, 9 or 16 data bits change nothing.
- R4: A committed write status copies data bits 4 to 2 into the protect field. The other data bits have no effect on the latch, the busy flag or any other status bit.
- R5: A write status command sent while the write-enable latch is 0 is ignored.
- R6: A committed write status sets the busy flag (status bit 0) for exactly WR_CYCLES system clock cycles, after which it reads 0.
- R7: The write-enable latch returns to 0 when the busy period ends.
- R8: The output enable is low while chip select is high. It is high while read status data is being shifted out.
- R9: While the busy flag is 1, write enable and write status commands are ignored. Read status still works.
- R10: After reset, the latch, the busy flag, the protect field and the output enable are all 0.
- R11: The bp_o port always equals the protect field of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n_i | input | 1 | Active-low chip select from the link |
| sck_i | input | 1 | Serial clock from the link |
| mosi_i | input | 1 | Serial data into the device |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Output enable for the data-out pad; the pad is high impedance when this is 0 |
| bp_o | output | 3 | Current block-protect field |

## Verification
The assertions assume the link runs much slower than the system clock. Each serial clock level, and each chip select level, must last several system cycles so that the two-stage synchroniser sees every edge. They also assume chip select never changes in the same cycle as a serial clock edge, and that data in is stable across each rising serial clock edge. The stimulus meets these conditions: it holds every serial clock half period for eight system cycles and changes data in only while the serial clock is low. It also moves chip select a full half period away from any serial clock edge, and waits out each busy period before starting a new write, unless the test deliberately targets the busy window.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int BYTE_W     = 8;
  localparam int BIT_CNT_W  = $clog2(BYTE_W);
  localparam int SYNC_DEPTH = 2;

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int BP_LSB  = 2;
  localparam int BP_W    = 3;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : gen_stage
    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] r_in;
    if (g == 0) begin : gen_first
      assign r_in = d_i;
    end else begin : gen_next
      assign r_in = gen_stage[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= r_in;
    end
  end

  assign q_o = gen_stage[STAGES-1].r;
endmodule

// File: rtl/sfs_frame.sv
module sfs_frame
  import sfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_s,
  input  logic            sck_s,
  input  logic            mosi_s,
  input  byte_t           status_i,
  output logic            wren_req_o,
  output logic            wrsr_req_o,
  output logic [BP_W-1:0] wrsr_bp_o,
  output logic            miso_o,
  output logic            miso_oe_o
);
  logic                 sck_q, cs_q;
  logic [BIT_CNT_W-1:0] bit_cnt, bit_cnt_n;
  logic [1:0]           byte_cnt, byte_cnt_n;
  logic [BYTE_W-2:0]    shreg, shreg_n;
  byte_t                opcode, opcode_n;
  logic [BP_W-1:0]      bp_q, bp_n;
  logic                 rd_act, rd_act_n;
  logic [BIT_CNT_W-1:0] tx_bit, tx_bit_n;
  logic                 miso_q, miso_n;
  logic                 oe_q, oe_n;
  logic                 sck_rise, sck_fall, cs_rise, boundary;
  byte_t                new_byte;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_q;
  assign new_byte = {shreg, mosi_s};
  assign boundary = (bit_cnt == '0);

  always_comb begin
    bit_cnt_n  = bit_cnt;
    byte_cnt_n = byte_cnt;
    shreg_n    = shreg;
    opcode_n   = opcode;
    bp_n       = bp_q;
    rd_act_n   = rd_act;
    tx_bit_n   = tx_bit;
    miso_n     = miso_q;
    oe_n       = oe_q;
    if (cs_n_s) begin
      bit_cnt_n  = '0;
      byte_cnt_n = '0;
      rd_act_n   = 1'b0;
      tx_bit_n   = '0;
      oe_n       = 1'b0;
    end else begin
      if (sck_rise) begin
        shreg_n   = new_byte[BYTE_W-2:0];
        bit_cnt_n = bit_cnt + 1'b1;
        if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
          if (byte_cnt == 2'd0) begin
            opcode_n = new_byte;
            rd_act_n = (new_byte == OP_RDSR);
          end else if (byte_cnt == 2'd1) begin
            bp_n = new_byte[BP_LSB +: BP_W];
          end
          byte_cnt_n = (byte_cnt == 2'd3) ? byte_cnt : byte_cnt + 2'd1;
        end
      end
      if (sck_fall && rd_act) begin
        miso_n   = status_i[3'(BYTE_W - 1) - tx_bit];
        tx_bit_n = tx_bit + 1'b1;
        oe_n     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      opcode   <= '0;
      bp_q     <= '0;
      rd_act   <= 1'b0;
      tx_bit   <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      cs_q     <= cs_n_s;
      bit_cnt  <= bit_cnt_n;
      byte_cnt <= byte_cnt_n;
      rd_act   <= rd_act_n;
      tx_bit   <= tx_bit_n;
      oe_q     <= oe_n;
      if (sck_rise) shreg  <= shreg_n;
      if (sck_rise) opcode <= opcode_n;
      if (sck_rise) bp_q   <= bp_n;
      if (sck_fall) miso_q <= miso_n;
    end
  end

  assign wren_req_o = cs_rise & boundary & (byte_cnt == 2'd1) & (opcode == OP_WREN);
  assign wrsr_req_o = cs_rise & boundary & (byte_cnt == 2'd2) & (opcode == OP_WRSR);
  assign wrsr_bp_o  = bp_q;
  assign miso_o     = miso_q;
  assign miso_oe_o  = oe_q;
endmodule

// File: rtl/sfs_status.sv
module sfs_status
  import sfs_pkg::*;
#(
  parameter int WR_CYCLES = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wren_req_i,
  input  logic            wrsr_req_i,
  input  logic [BP_W-1:0] wrsr_bp_i,
  output byte_t           status_o,
  output logic            wel_o,
  output logic            busy_o,
  output logic [BP_W-1:0] bp_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic            wel, wel_n;
  logic            busy, busy_n;
  logic [BP_W-1:0] bp, bp_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    wel_n  = wel;
    busy_n = busy;
    bp_n   = bp;
    cnt_n  = cnt;
    if (busy) begin
      if (cnt == CNT_W'(1)) begin
        busy_n = 1'b0;
        wel_n  = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end else if (wrsr_req_i && wel) begin
      bp_n   = wrsr_bp_i;
      busy_n = 1'b1;
      cnt_n  = CNT_W'(WR_CYCLES);
    end else if (wren_req_i) begin
      wel_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      busy <= 1'b0;
      bp   <= '0;
      cnt  <= '0;
    end else begin
      wel  <= wel_n;
      busy <= busy_n;
      bp   <= bp_n;
      cnt  <= cnt_n;
    end
  end

  always_comb begin
    status_o                  = '0;
    status_o[ST_BUSY]         = busy;
    status_o[ST_WEL]          = wel;
    status_o[BP_LSB +: BP_W]  = bp;
  end

  assign wel_o  = wel;
  assign busy_o = busy;
  assign bp_o   = bp;
endmodule

// File: rtl/sflash_status_resp.sv
module sflash_status_resp
  import sfs_pkg::*;
#(
  parameter int WR_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  output logic [2:0] bp_o
);
  logic            rst_sync_n;
  logic [2:0]      link_s;
  logic            wren_req, wrsr_req, wel, busy;
  logic [BP_W-1:0] wrsr_bp, bp;
  byte_t           status;

  sfs_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  sfs_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b001)) u_link_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i({mosi_i, sck_i, cs_n_i}), .q_o(link_s)
  );

  sfs_frame u_frame (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_n_s(link_s[0]), .sck_s(link_s[1]), .mosi_s(link_s[2]),
    .status_i(status),
    .wren_req_o(wren_req), .wrsr_req_o(wrsr_req), .wrsr_bp_o(wrsr_bp),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  sfs_status #(.WR_CYCLES(WR_CYCLES)) u_status (
    .clk(clk), .rst_n(rst_sync_n),
    .wren_req_i(wren_req), .wrsr_req_i(wrsr_req), .wrsr_bp_i(wrsr_bp),
    .status_o(status), .wel_o(wel), .busy_o(busy), .bp_o(bp)
  );

  assign bp_o = bp;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int WR_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       cs_n_i,
  input logic       miso_oe_o,
  input logic [2:0] bp_o,
  input logic       busy,
  input logic       wel,
  input logic       wrsr_req
);
  localparam int CW = $clog2(WR_CYCLES + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  busy_len <= '0;
    else if (busy)    busy_len <= busy_len + 1'b1;
    else              busy_len <= '0;
  end

  // R8: two synchroniser stages plus the enable register give three cycles
  a_r8_oe_low_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cs_n_i, 3) |-> !miso_oe_o);

  a_r3_commit_needs_frame: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(wrsr_req));

  a_r5_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(wel));

  a_r4_bp_only_on_commit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$rose(busy) |-> $stable(bp_o));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (busy_len == CW'(WR_CYCLES)));

  a_r7_wel_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> !wel);

  a_r9_no_wel_rise_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wel) |-> !$past(busy));
endmodule

bind sflash_status_resp sfs_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cs_n_i(cs_n_i), .miso_oe_o(miso_oe_o),
  .bp_o(bp_o), .busy(busy), .wel(wel), .wrsr_req(wrsr_req)
);

// File: tb/sflash_status_resp_tb.sv
module sflash_status_resp_tb;
  localparam int WR_CYC = 2000;
  localparam int HALF   = 8;
  localparam int NVEC   = 8;
  // vector: {wren_first[13], data_bits[12:8], data[7:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 5'd8,  8'h1C},
    {1'b1, 5'd8,  8'hFF},
    {1'b1, 5'd7,  8'h00},
    {1'b0, 5'd9,  8'h00},
    {1'b0, 5'd8,  8'h08},
    {1'b1, 5'd16, 8'h14},
    {1'b1, 5'd8,  8'h10},
    {1'b1, 5'd8,  8'h00}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi;
  logic miso, miso_oe;
  logic [2:0] bp;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic       m_wel;
  logic [2:0] m_bp;

  always #2 clk = ~clk;

  sflash_status_resp #(.WR_CYCLES(WR_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .bp_o(bp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    mosi = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
  endtask

  task automatic frame(input logic [7:0] op, input logic [15:0] pay, input int n);
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) sbit(op[i]);
    for (int i = 0; i < n; i++) sbit(pay[15-i]);
    tick(HALF); cs_n = 1'b1; tick(2*HALF);
  endtask

  task automatic rd_status(input string req, input logic [7:0] exp);
    logic [15:0] got;
    int oe_bad;
    oe_bad = 0;
    cs_n = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) sbit(sfs_pkg::OP_RDSR[i]);
    for (int i = 15; i >= 0; i--) begin
      tick(HALF);
      got[i] = miso;
      if (miso_oe !== 1'b1) oe_bad++;
      sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    tick(HALF); cs_n = 1'b1; tick(2*HALF);
    check({req, " first byte"}, int'(got[15:8]), int'(exp));
    check("R2 repeated byte", int'(got[7:0]), int'(exp));
    check("R8 oe high during read", oe_bad, 0);
    check("R8 oe low after deselect", int'(miso_oe), 0);
  endtask

  function automatic logic [7:0] sbyte(input logic [2:0] b, input logic w, input logic y);
    return {3'b000, b, w, y};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    tick(5); rst_n = 1'b1; tick(10);

    // R10 reset state
    check("R10 bp after reset", int'(bp), 0);
    check("R10 oe after reset", int'(miso_oe), 0);
    rd_status("R10 status after reset", 8'h00);
    m_wel = 1'b0; m_bp = 3'b000;

    // table walk: R3 R4 R5 R6 R7 R11
    for (int k = 0; k < NVEC; k++) begin
      logic commit;
      if (VEC[k][13]) begin
        frame(sfs_pkg::OP_WREN, 16'h0, 0);
        m_wel = 1'b1;
      end
      frame(sfs_pkg::OP_WRSR, {VEC[k][7:0], 8'h00}, int'(VEC[k][12:8]));
      commit = m_wel && (VEC[k][12:8] == 5'd8);
      if (commit) begin
        m_bp = VEC[k][4:2];
        rd_status("R6 busy during write", sbyte(m_bp, 1'b1, 1'b1));
        tick(WR_CYC);
        m_wel = 1'b0;
      end
      check("R11 bp_o port", int'(bp), int'(m_bp));
      rd_status("R3 R4 R5 R7 status after vector", sbyte(m_bp, m_wel, 1'b0));
    end

    // R9 writes ignored while busy
    frame(sfs_pkg::OP_WREN, 16'h0, 0);
    frame(sfs_pkg::OP_WRSR, 16'h0C00, 8);
    frame(sfs_pkg::OP_WRSR, 16'h1C00, 8);
    frame(sfs_pkg::OP_WREN, 16'h0, 0);
    rd_status("R9 read allowed while busy", sbyte(3'b011, 1'b1, 1'b1));
    tick(WR_CYC);
    check("R9 bp kept after busy writes", int'(bp), 3);
    rd_status("R9 R7 status after busy", sbyte(3'b011, 1'b0, 1'b0));

    // R1 write enable with extra bit is discarded, exact frame accepted
    frame(sfs_pkg::OP_WREN, 16'h8000, 1);
    rd_status("R1 padded enable ignored", sbyte(3'b011, 1'b0, 1'b0));
    frame(sfs_pkg::OP_WREN, 16'h0, 0);
    rd_status("R1 enable sets latch", sbyte(3'b011, 1'b1, 1'b0));

    // R10 reset in mid operation
    rst_n = 1'b0; tick(3);
    check("R10 bp under reset", int'(bp), 0);
    rst_n = 1'b1; tick(10);
    rd_status("R10 status after second reset", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule